// File: doc/BRIEF.md
# Event-to-Interrupt Aggregator

This block turns single-cycle event pulses into level interrupts. Each pulse arrives with a global event number. A programmable steering table looks that number up and finds one virtual-interrupt slice and one of the slice's 64 status bits. The block then latches that bit. Every slice combines its latched status with its own enable mask and drives one active-high level line towards the interrupt router. Software acknowledges an event by writing a one to its status bit.

Software reaches the block through a plain 64-bit register port that writes in a single cycle and reads combinationally. The lower half of the address space holds one 4 KiB page per slice, each with enable-set, enable-clear and status words. When the top address bit is set, the access goes to the steering-table window instead, with one 64-bit word per global event.

Top module: `evt_irq_aggregator`

## Requirements
- R1: After reset, every interrupt line is low, every enable and status word reads zero, and every steering entry reads zero, so no event is routed anywhere.
- R2: A pulse on `evt_valid` whose steering entry is valid sets that entry's status bit in that entry's slice at the next rising clock edge. Status words in all other slices are left unchanged.
- R3: A pulse whose steering entry has the valid bit (bit 31) at zero changes no status bit.
- R4: Writing page offset 0x0 sets every enable bit where the written data is one and leaves the other enable bits as they were. A read at offset 0x0 or at offset 0x8 returns the current enable mask.
- R5: Writing page offset 0x8 clears every enable bit where the written data is one and leaves the other enable bits as they were.
- R6: A status bit latches whether or not its enable bit is set. Slice line `vint_irq[v]` is high exactly when some bit is set in both the status word and the enable mask of slice v.
- R7: Writing page offset 0x18 clears every status bit where the written data is one. Bits written as zero are kept.
- R8: When a pulse sets a status bit in the same cycle as a write that clears that same bit through offset 0x18, the bit ends up set.
- R9: Slice v's page starts at byte address v·0x1000. Steering entry e sits at byte address 0x8000 + 8·e. An entry holds the valid flag at bit 31, the slice number at bits 10:8 and the status bit number at bits 5:0, and it reads back in that same layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Event pulse, one cycle |
| evt_num | input | 8 | Global event number of the pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data, combinational |
| vint_irq | output | 8 | Level interrupt, one line per slice |

## Verification
Two things can land on the same cycle: a routed event setting a status bit, and a software acknowledge write to the status word of the same slice. The bench provokes this by driving an event pulse and a write to offset 0x18 on one clock. In one case the write clears the very bit the event sets. In the other case the write clears a neighbouring bit as well. A read-back of the status word afterwards decides the result: the event's bit must be set, and only the neighbouring bit must be cleared.

// File: rtl/eia_pkg.sv
package eia_pkg;
  localparam int STAT_W     = 64;
  localparam int BIT_W      = 6;
  localparam int PAGE_SHIFT = 12;
  localparam int WORD_SHIFT = 3;

  localparam logic [PAGE_SHIFT-1:0] OFS_EN_SET = 12'h000;
  localparam logic [PAGE_SHIFT-1:0] OFS_EN_CLR = 12'h008;
  localparam logic [PAGE_SHIFT-1:0] OFS_STATUS = 12'h018;

  localparam int ENT_VALID_POS = 31;
  localparam int ENT_SLICE_LSB = 8;
  localparam int ENT_BIT_LSB   = 0;
endpackage

// File: rtl/eia_map_table.sv
module eia_map_table #(
  parameter int NUM_EVT  = 256,
  parameter int NUM_VINT = 8,
  localparam int EVT_W  = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1,
  localparam int VINT_W = (NUM_VINT > 1) ? $clog2(NUM_VINT) : 1,
  localparam int BIT_W  = eia_pkg::BIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [EVT_W-1:0]  acc_idx,
  input  logic              wr_valid,
  input  logic [VINT_W-1:0] wr_vint,
  input  logic [BIT_W-1:0]  wr_bit,
  output logic              rd_valid,
  output logic [VINT_W-1:0] rd_vint,
  output logic [BIT_W-1:0]  rd_bit,
  input  logic [EVT_W-1:0]  lk_idx,
  output logic              lk_valid,
  output logic [VINT_W-1:0] lk_vint,
  output logic [BIT_W-1:0]  lk_bit
);
  logic              valid_q [NUM_EVT];
  logic [VINT_W-1:0] vint_q  [NUM_EVT];
  logic [BIT_W-1:0]  bit_q   [NUM_EVT];

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_ent
    logic ent_we;
    assign ent_we = wr_en && (acc_idx == EVT_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[i] <= 1'b0;
        vint_q[i]  <= '0;
        bit_q[i]   <= '0;
      end else if (ent_we) begin
        valid_q[i] <= wr_valid;
        vint_q[i]  <= wr_vint;
        bit_q[i]   <= wr_bit;
      end
    end
  end

  always_comb begin
    rd_valid = valid_q[acc_idx];
    rd_vint  = vint_q[acc_idx];
    rd_bit   = bit_q[acc_idx];
    lk_valid = valid_q[lk_idx];
    lk_vint  = vint_q[lk_idx];
    lk_bit   = bit_q[lk_idx];
  end

  // R9: a table write is visible at the read port on the next cycle when the index is held
  assert_tbl_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_valid) ##1 $stable(acc_idx) |-> rd_valid);
endmodule

// File: rtl/eia_vint_slice.sv
module eia_vint_slice #(
  parameter int STAT_W = eia_pkg::STAT_W,
  localparam int BIT_W = $clog2(STAT_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [BIT_W-1:0]  hit_bit,
  input  logic              en_set_we,
  input  logic              en_clr_we,
  input  logic              st_clr_we,
  input  logic [STAT_W-1:0] wdata,
  output logic [STAT_W-1:0] enable,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  logic [STAT_W-1:0] en_q, en_d, st_q, st_d;
  logic              upd;

  always_comb begin
    en_d = en_q;
    if (en_set_we) en_d = en_d | wdata;
    if (en_clr_we) en_d = en_d & ~wdata;
    st_d = st_q;
    if (st_clr_we) st_d = st_d & ~wdata;
    if (hit)       st_d[hit_bit] = 1'b1;   // set has priority over acknowledge
  end

  assign upd = hit | en_set_we | en_clr_we | st_clr_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      st_q <= '0;
    end else if (upd) begin
      en_q <= en_d;
      st_q <= st_d;
    end
  end

  assign enable = en_q;
  assign status = st_q;
  assign irq    = |(st_q & en_q);

  // R2, R8: a hit always leaves its bit set, even against a same-cycle acknowledge
  assert_hit_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> status[$past(hit_bit)]);
  // R4: every bit written as one is enabled afterwards
  assert_enset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en_set_we |=> ((enable & $past(wdata)) == $past(wdata)));
  // R5: every bit written as one is disabled afterwards
  assert_enclr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr_we |=> ((enable & $past(wdata)) == '0));
  // R7: bits written as zero keep their status through an acknowledge
  assert_ack_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_clr_we && !hit) |=> ((status & ~$past(wdata)) == ($past(status) & ~$past(wdata))));
  // R6: a raised level stays up until software acknowledges or disables
  assert_level_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !st_clr_we && !en_clr_we) |=> irq);
endmodule

// File: rtl/evt_irq_aggregator.sv
module evt_irq_aggregator #(
  parameter int NUM_VINT = 8,
  parameter int NUM_EVT  = 256,
  localparam int VINT_W   = (NUM_VINT > 1) ? $clog2(NUM_VINT) : 1,
  localparam int EVT_W    = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1,
  localparam int PAGE_TOP = eia_pkg::PAGE_SHIFT + VINT_W,
  localparam int MAP_TOP  = EVT_W + eia_pkg::WORD_SHIFT,
  localparam int ADDR_W   = ((PAGE_TOP > MAP_TOP) ? PAGE_TOP : MAP_TOP) + 1,
  localparam int STAT_W   = eia_pkg::STAT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                evt_valid,
  input  logic [EVT_W-1:0]    evt_num,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [STAT_W-1:0]   reg_wdata,
  output logic [STAT_W-1:0]   reg_rdata,
  output logic [NUM_VINT-1:0] vint_irq
);
  import eia_pkg::*;

  logic                  win_map, page_ok;
  logic [VINT_W-1:0]     page_idx;
  logic [PAGE_SHIFT-1:0] page_ofs;
  logic [EVT_W-1:0]      ent_idx;
  logic                  map_we;

  assign win_map  = reg_addr[ADDR_W-1];
  assign page_idx = reg_addr[PAGE_SHIFT +: VINT_W];
  assign page_ofs = reg_addr[PAGE_SHIFT-1:0];
  assign ent_idx  = reg_addr[WORD_SHIFT +: EVT_W];
  assign map_we   = reg_wr && win_map;

  if (NUM_VINT == (1 << VINT_W)) begin : g_pg_full
    assign page_ok = !win_map;
  end else begin : g_pg_part
    assign page_ok = !win_map && (int'(page_idx) < NUM_VINT);
  end

  logic              rd_valid, lk_valid;
  logic [VINT_W-1:0] rd_vint, lk_vint;
  logic [BIT_W-1:0]  rd_bit, lk_bit;

  eia_map_table #(.NUM_EVT(NUM_EVT), .NUM_VINT(NUM_VINT)) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (map_we),
    .acc_idx  (ent_idx),
    .wr_valid (reg_wdata[ENT_VALID_POS]),
    .wr_vint  (reg_wdata[ENT_SLICE_LSB +: VINT_W]),
    .wr_bit   (reg_wdata[ENT_BIT_LSB +: BIT_W]),
    .rd_valid (rd_valid),
    .rd_vint  (rd_vint),
    .rd_bit   (rd_bit),
    .lk_idx   (evt_num),
    .lk_valid (lk_valid),
    .lk_vint  (lk_vint),
    .lk_bit   (lk_bit)
  );

  logic [NUM_VINT-1:0] hit_v;
  logic [STAT_W-1:0]   en_all [NUM_VINT];
  logic [STAT_W-1:0]   st_all [NUM_VINT];

  for (genvar v = 0; v < NUM_VINT; v++) begin : g_slice
    logic sel;
    assign sel      = reg_wr && page_ok && (page_idx == VINT_W'(v));
    assign hit_v[v] = evt_valid && lk_valid && (lk_vint == VINT_W'(v));
    eia_vint_slice #(.STAT_W(STAT_W)) u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (hit_v[v]),
      .hit_bit   (lk_bit),
      .en_set_we (sel && (page_ofs == OFS_EN_SET)),
      .en_clr_we (sel && (page_ofs == OFS_EN_CLR)),
      .st_clr_we (sel && (page_ofs == OFS_STATUS)),
      .wdata     (reg_wdata),
      .enable    (en_all[v]),
      .status    (st_all[v]),
      .irq       (vint_irq[v])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (win_map) begin
      reg_rdata[ENT_VALID_POS]            = rd_valid;
      reg_rdata[ENT_SLICE_LSB +: VINT_W]  = rd_vint;
      reg_rdata[ENT_BIT_LSB +: BIT_W]     = rd_bit;
    end else if (page_ok) begin
      case (page_ofs)
        OFS_EN_SET, OFS_EN_CLR: reg_rdata = en_all[page_idx];
        OFS_STATUS:             reg_rdata = st_all[page_idx];
        default:                reg_rdata = '0;
      endcase
    end
  end

  logic unused_addr_bits;
  assign unused_addr_bits = ^reg_addr[WORD_SHIFT-1:0];

  // R2: a pulse is steered to at most one slice
  assert_route_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_v));
  // R3: an invalid steering entry lets no pulse through
  assert_drop_invalid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !lk_valid) |-> (hit_v == '0));
endmodule

// File: tb/evt_irq_aggregator_tb_top.sv
`timescale 1ns/1ps
module evt_irq_aggregator_tb_top;
  localparam int OP_WR = 0, OP_RD = 1, OP_EV = 2, OP_EVWR = 3, OP_IRQ = 4;

  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] addr;
    logic [63:0] data;
    logic [7:0]  evt;
    logic [63:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 45;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 16'h0000, 64'h0, 8'd0, 64'h0, 4'd1},                 // R1 enable clear
    '{3'd1, 16'h0018, 64'h0, 8'd0, 64'h0, 4'd1},                 // R1 status clear
    '{3'd1, 16'h8028, 64'h0, 8'd0, 64'h0, 4'd1},                 // R1 entry invalid
    '{3'd4, 16'h0000, 64'h0, 8'd0, 64'h0, 4'd1},                 // R1 lines low
    '{3'd2, 16'h0000, 64'h0, 8'd5, 64'h0, 4'd3},                 // R3 unmapped pulse
    '{3'd1, 16'h0018, 64'h0, 8'd0, 64'h0, 4'd3},                 // R3
    '{3'd1, 16'h2018, 64'h0, 8'd0, 64'h0, 4'd3},                 // R3
    '{3'd0, 16'h8028, 64'h80000203, 8'd0, 64'h0, 4'd9},          // R9 map 5 -> slice2 bit3
    '{3'd1, 16'h8028, 64'h0, 8'd0, 64'h80000203, 4'd9},          // R9 read back
    '{3'd2, 16'h0000, 64'h0, 8'd5, 64'h0, 4'd2},                 // R2 pulse
    '{3'd1, 16'h2018, 64'h0, 8'd0, 64'h8, 4'd2},                 // R2 bit set
    '{3'd1, 16'h1018, 64'h0, 8'd0, 64'h0, 4'd2},                 // R2 neighbour untouched
    '{3'd4, 16'h0000, 64'h0, 8'd0, 64'h0, 4'd6},                 // R6 latched but masked
    '{3'd0, 16'h2000, 64'h8, 8'd0, 64'h0, 4'd4},                 // R4 enable bit3
    '{3'd4, 16'h0000, 64'h0, 8'd0, 64'h04, 4'd6},                // R6 line 2 high
    '{3'd1, 16'h2008, 64'h0, 8'd0, 64'h8, 4'd4},                 // R4 read at 0x8
    '{3'd0, 16'h2000, 64'h0, 8'd0, 64'h0, 4'd4},                 // R4 zeros ignored
    '{3'd1, 16'h2000, 64'h0, 8'd0, 64'h8, 4'd4},                 // R4
    '{3'd0, 16'h2000, 64'hF000000000000000, 8'd0, 64'h0, 4'd4},  // R4 more bits
    '{3'd1, 16'h2000, 64'h0, 8'd0, 64'hF000000000000008, 4'd4},  // R4
    '{3'd0, 16'h2008, 64'h1000000000000000, 8'd0, 64'h0, 4'd5},  // R5 clear bit60
    '{3'd1, 16'h2000, 64'h0, 8'd0, 64'hE000000000000008, 4'd5},  // R5
    '{3'd0, 16'h2008, 64'h0, 8'd0, 64'h0, 4'd5},                 // R5 zeros ignored
    '{3'd1, 16'h2008, 64'h0, 8'd0, 64'hE000000000000008, 4'd5},  // R5
    '{3'd0, 16'h2018, 64'h0, 8'd0, 64'h0, 4'd7},                 // R7 zeros ignored
    '{3'd1, 16'h2018, 64'h0, 8'd0, 64'h8, 4'd7},                 // R7
    '{3'd0, 16'h2018, 64'h8, 8'd0, 64'h0, 4'd7},                 // R7 acknowledge
    '{3'd1, 16'h2018, 64'h0, 8'd0, 64'h0, 4'd7},                 // R7
    '{3'd4, 16'h0000, 64'h0, 8'd0, 64'h0, 4'd6},                 // R6 line drops
    '{3'd0, 16'h8640, 64'h8000073F, 8'd0, 64'h0, 4'd9},          // R9 map 200 -> slice7 bit63
    '{3'd2, 16'h0000, 64'h0, 8'd200, 64'h0, 4'd2},               // R2
    '{3'd1, 16'h7018, 64'h0, 8'd0, 64'h8000000000000000, 4'd9},  // R9 page of slice7
    '{3'd0, 16'h7000, 64'h8000000000000000, 8'd0, 64'h0, 4'd6},  // R6
    '{3'd4, 16'h0000, 64'h0, 8'd0, 64'h80, 4'd6},                // R6 line 7 high
    '{3'd0, 16'h8640, 64'h0000073F, 8'd0, 64'h0, 4'd3},          // R3 invalidate 200
    '{3'd0, 16'h7018, 64'h8000000000000000, 8'd0, 64'h0, 4'd7},  // R7
    '{3'd2, 16'h0000, 64'h0, 8'd200, 64'h0, 4'd3},               // R3 pulse dropped
    '{3'd1, 16'h7018, 64'h0, 8'd0, 64'h0, 4'd3},                 // R3
    '{3'd4, 16'h0000, 64'h0, 8'd0, 64'h0, 4'd3},                 // R3
    '{3'd2, 16'h0000, 64'h0, 8'd5, 64'h0, 4'd8},                 // R8 preset bit3
    '{3'd3, 16'h2018, 64'h8, 8'd5, 64'h0, 4'd8},                 // R8 set vs ack, same bit
    '{3'd1, 16'h2018, 64'h0, 8'd0, 64'h8, 4'd8},                 // R8 set wins
    '{3'd0, 16'h8030, 64'h80000204, 8'd0, 64'h0, 4'd8},          // R8 map 6 -> slice2 bit4
    '{3'd2, 16'h0000, 64'h0, 8'd6, 64'h0, 4'd8},                 // R8
    '{3'd3, 16'h2018, 64'h18, 8'd5, 64'h8, 4'd8}                 // R8 ack 0x18 while 5 fires
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        evt_valid;
  logic [7:0]  evt_num;
  logic        reg_wr;
  logic [15:0] reg_addr;
  logic [63:0] reg_wdata;
  logic [63:0] reg_rdata;
  logic [7:0]  vint_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  evt_irq_aggregator dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .evt_num   (evt_num),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .vint_irq  (vint_irq)
  );

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input int req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    @(negedge clk);
    reg_wr    = (v.op == OP_WR) || (v.op == OP_EVWR);
    evt_valid = (v.op == OP_EV) || (v.op == OP_EVWR);
    reg_addr  = v.addr;
    reg_wdata = v.data;
    evt_num   = v.evt;
    #1;
    if (v.op == OP_RD)  check(reg_rdata, v.exp, int'(v.req));
    if (v.op == OP_IRQ) check({56'h0, vint_irq}, v.exp, int'(v.req));
    @(posedge clk);
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [63:0] exp, input int req);
    vec_t v;
    v = '{3'd1, a, 64'h0, 8'd0, exp, 4'(req)};
    run_vec(v);
  endtask

  initial begin
    rst_n = 1'b0; evt_valid = 1'b0; evt_num = '0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R8 aftermath: status 0x8 with bit3 enabled keeps line 2 up
    rd_chk(16'h2018, 64'h8, 8);
    run_vec('{3'd4, 16'h0, 64'h0, 8'd0, 64'h04, 4'd6});       // R6

    // R1: reset in the middle of activity
    @(negedge clk);
    reg_wr = 1'b0; evt_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check({56'h0, vint_irq}, 64'h0, 1);                        // R1
    @(negedge clk);
    rst_n = 1'b1;
    rd_chk(16'h2000, 64'h0, 1);                                // R1
    rd_chk(16'h2018, 64'h0, 1);                                // R1
    rd_chk(16'h8028, 64'h0, 1);                                // R1
    run_vec('{3'd2, 16'h0, 64'h0, 8'd5, 64'h0, 4'd1});        // R1 table cleared
    rd_chk(16'h2018, 64'h0, 1);                                // R1

    @(negedge clk);
    reg_wr = 1'b0; evt_valid = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule